// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block sits after the floating-point instruction decoder. It accepts one decoded operation: destination and source register numbers, a precision flag, a one-source flag and the floating-point control word. It then issues the register triples that the execution pipeline must process, one triple per handshake on a valid/ready output. The banks that the destination and the last-named source fall in decide the mode: scalar, full vector or scalar-expanded. In the vector modes each register index moves forward by the programmed stride. It wraps inside its own bank, which holds 8 registers in single-precision numbering and 4 in double-precision numbering.

The element count and the stride come from two biased fields of the control word. Before any element is issued, a combination that would visit a register of the bank twice is rejected with a one-cycle error pulse. The block does not execute operations and does not access the register file.

Top module: `vec_index_seq`

## Requirements
- R1: When the destination is in bank 0, exactly one triple is issued, holding the named registers unchanged, and the length and stride fields are ignored. This includes combinations that would otherwise be rejected.
- R2: Bank membership is decided as follows.
  - Single precision (`in_dbl`=0) uses register numbers 0..31 in banks of 8, and bank 0 is registers 0..7.
  - Double precision (`in_dbl`=1) uses bits 3:0 only, in banks of 4, and bank 0 is registers 0..3.
  - In double precision, bit 4 of an input is ignored and bit 4 of every output register is 0.
- R3: The element count is control bits 18:16 plus one, so 000 gives 1 element and 111 gives 8.
- R4: The stride is control bits 21:20 plus one, so 00 gives stride 1 and 11 gives stride 4.
- R5: In full vector mode (neither the destination nor the last-named source in bank 0), element k of register r is (r − r mod N) + ((r mod N + k·stride) mod N), with N = 8 for single and N = 4 for double. This applies to every register.
- R6: In scalar-expanded mode (last-named source in bank 0, destination not), the last-named source stays fixed for every element while the other registers step as in R5.
- R7: When `in_one_src`=1, the last-named source is `in_src1` and `op_src2` is driven as 0.
- R8: In a vector mode, a length/stride pair under which any register would repeat is rejected. `err` is then high for exactly the cycle after acceptance, no triple is issued, and neither `busy` nor `done` rises.
- R9: While `op_valid` is high and `op_ready` is low, the triple and `op_valid` hold steady.
- R10: Timing of `busy`, `in_ready` and `done`:
  - `busy` rises in the cycle after a legal operation is accepted and stays high until the handshake of the final element.
  - `in_ready` is the inverse of `busy`.
  - `done` is high for exactly the one cycle after the final handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded operation offered |
| in_ready | output | 1 | Sequencer idle, operation taken on this edge |
| in_dbl | input | 1 | 1 = double-precision numbering |
| in_one_src | input | 1 | 1 = operation has only one source |
| in_dst | input | 5 | Destination register number |
| in_src1 | input | 5 | First source register number |
| in_src2 | input | 5 | Second source register number |
| in_ctrl | input | 32 | Floating-point control word (length and stride fields) |
| op_valid | output | 1 | Triple on the output is valid |
| op_ready | input | 1 | Consumer takes the triple on this edge |
| op_dst | output | 5 | Destination index of the current element |
| op_src1 | output | 5 | First source index of the current element |
| op_src2 | output | 5 | Second source index of the current element |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final element |
| err | output | 1 | One-cycle pulse for a rejected length/stride pair |

## Verification
Element 0 appears one cycle after the accepting edge. Each later element appears one cycle after the handshake of the element before it. `done` or `err` is high in the single cycle after the final handshake or after the rejected acceptance. The bench drives on the falling edge and samples on the next falling edge. Each element is compared in the half cycle before the edge that consumes it, and each pulse is checked in exactly one cycle and seen to be gone in the following one. Stalls hold `op_ready` low across several falling edges and compare the triple each time.

// File: rtl/vec_index_seq.sv
module vec_index_seq #(
  parameter int CW      = 32,
  parameter int LEN_LSB = 16,
  parameter int STR_LSB = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_dbl,
  input  logic          in_one_src,
  input  logic [4:0]    in_dst,
  input  logic [4:0]    in_src1,
  input  logic [4:0]    in_src2,
  input  logic [CW-1:0] in_ctrl,
  output logic          op_valid,
  input  logic          op_ready,
  output logic [4:0]    op_dst,
  output logic [4:0]    op_src1,
  output logic [4:0]    op_src2,
  output logic          busy,
  output logic          done,
  output logic          err
);

  function automatic logic in_bank0(input logic [4:0] r, input logic d);
    return d ? (r[3:2] == 2'b00) : (r[4:3] == 2'b00);
  endfunction

  function automatic logic [4:0] norm(input logic [4:0] r, input logic d);
    return d ? {1'b0, r[3:0]} : r;
  endfunction

  function automatic logic [4:0] step(input logic [4:0] r, input logic [2:0] s, input logic d);
    logic [2:0] lo3;
    logic [1:0] lo2;
    lo3 = r[2:0] + s;
    lo2 = r[1:0] + s[1:0];
    return d ? {1'b0, r[3:2], lo2} : {r[4:3], lo3};
  endfunction

  logic [2:0] len_c;
  logic [1:0] str_c;
  logic [4:0] d_n, a_n, b_n, last_n;
  logic       scal, fix_last, legal, accept;
  logic [3:0] period;
  logic [1:0] tz;

  assign len_c    = in_ctrl[LEN_LSB +: 3];
  assign str_c    = in_ctrl[STR_LSB +: 2];
  assign d_n      = norm(in_dst, in_dbl);
  assign a_n      = norm(in_src1, in_dbl);
  assign b_n      = in_one_src ? 5'd0 : norm(in_src2, in_dbl);
  assign last_n   = in_one_src ? a_n : b_n;
  assign scal     = in_bank0(d_n, in_dbl);
  assign fix_last = !scal && in_bank0(last_n, in_dbl);
  assign tz       = (str_c == 2'd1) ? 2'd1 : (str_c == 2'd3) ? 2'd2 : 2'd0;
  assign period   = (in_dbl ? 4'd4 : 4'd8) >> tz;
  assign legal    = scal || ({1'b0, len_c} < period);
  assign accept   = in_valid && !busy;

  logic [2:0] rem, stp;
  logic       dbl_q, one_q, fix_q;
  logic [4:0] cd, ca, cb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      rem   <= '0;
      stp   <= 3'd1;
      dbl_q <= 1'b0;
      one_q <= 1'b0;
      fix_q <= 1'b0;
      cd    <= '0;
      ca    <= '0;
      cb    <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (accept) begin
        if (legal) begin
          busy  <= 1'b1;
          rem   <= scal ? 3'd0 : len_c;
          stp   <= {1'b0, str_c} + 3'd1;
          dbl_q <= in_dbl;
          one_q <= in_one_src;
          fix_q <= fix_last;
          cd    <= d_n;
          ca    <= a_n;
          cb    <= b_n;
        end else begin
          err <= 1'b1;
        end
      end else if (busy && op_ready) begin
        if (rem == 3'd0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rem <= rem - 3'd1;
          cd  <= step(cd, stp, dbl_q);
          if (!(fix_q && one_q)) ca <= step(ca, stp, dbl_q);
          if (!one_q && !fix_q)  cb <= step(cb, stp, dbl_q);
        end
      end
    end
  end

  assign in_ready = !busy;
  assign op_valid = busy;
  assign op_dst   = cd;
  assign op_src1  = ca;
  assign op_src2  = cb;

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_dst) && $stable(op_src1) && $stable(op_src2));

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  done_needs_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid && op_ready));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !op_valid && !done);

  // R2
  dbl_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && dbl_q |-> !op_dst[4] && !op_src1[4] && !op_src2[4]);

  // R7
  one_src_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && one_q |-> op_src2 == 5'd0);

endmodule

// File: tb/test_vec_index_seq.sv
module test_vec_index_seq;
  localparam int PERIOD = 10;

  typedef struct packed {
    logic       dbl;
    logic       one;
    logic [4:0] d;
    logic [4:0] a;
    logic [4:0] b;
    logic [2:0] lc;
    logic [1:0] sc;
    logic [3:0] n;
    logic       e;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 5'd3,  5'd9,  5'd17, 3'd7, 2'd3, 4'd1, 1'b0}, // R1 scalar, illegal pair ignored
    '{1'b0, 1'b0, 5'd8,  5'd16, 5'd24, 3'd3, 2'd0, 4'd4, 1'b0}, // R5 R3
    '{1'b0, 1'b0, 5'd13, 5'd22, 5'd31, 3'd7, 2'd2, 4'd8, 1'b0}, // R5 R4 wrap stride 3
    '{1'b0, 1'b0, 5'd10, 5'd18, 5'd5,  3'd3, 2'd1, 4'd4, 1'b0}, // R6
    '{1'b0, 1'b0, 5'd8,  5'd16, 5'd24, 3'd4, 2'd1, 4'd0, 1'b1}, // R8
    '{1'b1, 1'b0, 5'd5,  5'd10, 5'd14, 3'd3, 2'd0, 4'd4, 1'b0}, // R2 R5
    '{1'b1, 1'b0, 5'd6,  5'd9,  5'd2,  3'd1, 2'd1, 4'd2, 1'b0}, // R6 double
    '{1'b1, 1'b0, 5'd6,  5'd9,  5'd10, 3'd1, 2'd3, 4'd0, 1'b1}, // R8 double
    '{1'b0, 1'b1, 5'd12, 5'd3,  5'd29, 3'd2, 2'd0, 4'd3, 1'b0}, // R7 expanded
    '{1'b1, 1'b1, 5'd4,  5'd13, 5'd7,  3'd3, 2'd2, 4'd4, 1'b0}, // R7 vector
    '{1'b1, 1'b0, 5'd21, 5'd24, 5'd17, 3'd0, 2'd0, 4'd1, 1'b0}, // R2 bit4 ignored
    '{1'b0, 1'b0, 5'd8,  5'd16, 5'd24, 3'd1, 2'd3, 4'd2, 1'b0}  // R4 stride 4
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_dbl = 0, in_one_src = 0, op_ready = 1;
  logic [4:0] in_dst = 0, in_src1 = 0, in_src2 = 0;
  logic [31:0] in_ctrl = 0;
  logic in_ready, op_valid, busy, done, err;
  logic [4:0] op_dst, op_src1, op_src2;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  vec_index_seq i_vec_index_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dbl(in_dbl), .in_one_src(in_one_src), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_ctrl(in_ctrl),
    .op_valid(op_valid), .op_ready(op_ready), .op_dst(op_dst),
    .op_src1(op_src1), .op_src2(op_src2), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] elem(input logic [4:0] r, input int k, input int s, input logic d);
    int nb, rr;
    nb = d ? 4 : 8;
    rr = d ? int'(r & 5'd15) : int'(r);
    return 5'((rr / nb) * nb + ((rr % nb) + k * s) % nb);
  endfunction

  function automatic bit b0(input logic [4:0] r, input logic d);
    return d ? ((r & 5'd15) < 4) : (r < 8);
  endfunction

  task automatic launch(input vec_t v);
    @(negedge clk);
    in_valid = 1; in_dbl = v.dbl; in_one_src = v.one;
    in_dst = v.d; in_src1 = v.a; in_src2 = v.b;
    in_ctrl = 32'h0 | (32'(v.lc) << 16) | (32'(v.sc) << 20) | 32'h8c00_0003;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run(input vec_t v, input int stall_cycles);
    int s;
    logic [4:0] ed, ea, eb, lastr;
    bit scal, fixl;
    s = int'(v.sc) + 1;
    scal = b0(v.d, v.dbl);
    lastr = v.one ? v.a : v.b;
    fixl = !scal && b0(lastr, v.dbl);
    op_ready = (stall_cycles == 0);
    launch(v);
    if (v.e) begin
      chk(err === 1'b1 && op_valid === 1'b0 && busy === 1'b0, "R8 err pulse", {err, op_valid, busy}, 3'b100);
      @(negedge clk);
      chk(err === 1'b0 && done === 1'b0 && op_valid === 1'b0, "R8 no issue", {err, done, op_valid}, 3'b000);
      op_ready = 1;
      return;
    end
    for (int k = 0; k < int'(v.n); k++) begin
      ed = elem(v.d, k, s, v.dbl);
      ea = (fixl && v.one) ? elem(v.a, 0, s, v.dbl) : elem(v.a, k, s, v.dbl);
      eb = v.one ? 5'd0 : (fixl ? elem(v.b, 0, s, v.dbl) : elem(v.b, k, s, v.dbl));
      if (k == 0 && stall_cycles > 0) begin
        for (int w = 0; w < stall_cycles; w++) begin
          chk(op_valid === 1'b1 && {op_dst, op_src1, op_src2} === {ed, ea, eb}, "R9 stall hold",
              {op_valid, op_dst, op_src1, op_src2}, {1'b1, ed, ea, eb});
          @(negedge clk);
        end
        op_ready = 1;
      end
      chk(op_valid === 1'b1 && busy === 1'b1 && in_ready === 1'b0 &&
          {op_dst, op_src1, op_src2} === {ed, ea, eb}, "R5/R6/R1 element",
          {op_valid, op_dst, op_src1, op_src2}, {1'b1, ed, ea, eb});
      @(negedge clk);
    end
    chk(done === 1'b1 && busy === 1'b0 && op_valid === 1'b0 && in_ready === 1'b1, "R10 done after last",
        {done, busy, op_valid, in_ready}, 4'b1001);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(op_valid === 0 && busy === 0 && in_ready === 1 && done === 0 && err === 0, "R10 reset state",
        {op_valid, busy, in_ready, done, err}, 5'b00100);
    for (int i = 0; i < NV; i++) run(TBL[i], 0);
    // R9: stall with backpressure on a vector sequence
    run(TBL[2], 3);
    // R3: length code 111 on double bank with stride 1 is illegal (8 > 4)
    v = '{1'b1, 1'b0, 5'd4, 5'd8, 5'd12, 3'd7, 2'd0, 4'd0, 1'b1};
    run(v, 0);
    // R3: length code 000 gives exactly one element in vector mode
    v = '{1'b0, 1'b0, 5'd30, 5'd14, 5'd23, 3'd0, 2'd3, 4'd1, 1'b0};
    run(v, 0);
    // R10: in_valid while busy is not taken
    launch(TBL[1]);
    in_valid = 1; in_dst = 5'd3;
    @(negedge clk);
    chk(op_dst === 5'd9 && busy === 1'b1, "R10 busy blocks accept", op_dst, 5'd9);
    in_valid = 0;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && op_valid === 1'b0, "R10 sequence ended", {busy, op_valid}, 2'b00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule